// File: doc/BRIEF.md
# Duplicate Command Input Validator

This block sits between a byte-wide serial command receiver and the command decoder of a playback controller. Each command is one or two bytes long. The high nibble of the first byte fixes the length: nibbles 0x0 to 0x7 mark one-byte commands and nibbles 0x8 to 0xF mark two-byte commands. With duplicate checking off, each complete command is released to the decoder as soon as its last byte arrives. With duplicate checking on, every command must be sent twice. It is released only when the second copy equals the first, byte for byte.

When the two copies differ, the command is discarded and a sticky error output goes high. The byte that showed the mismatch is dropped, and the byte after it starts a new first copy. The error stays high until an error-clear command (first byte with high nibble 0x7) is released. In duplicate mode that command must itself pass the duplicate check. The setup command (high nibble 0x8, two bytes) is released like any other command. Bit 0 of its second byte also switches duplicate mode on (1) or off (0), starting with the next command.

After each accepted byte the block holds busy high for a fixed number of cycles. The host must wait for busy to fall before it sends the next byte. A byte offered while busy is high is ignored.

Top module: `dup_cmd_gate`

## Requirements
- R1: After reset busy, err and cmd_valid are low and duplicate mode is off.
- R2: With duplicate mode off, a byte whose high nibble is 0x0-0x7 arriving as the first byte of a command is released alone: cmd_valid pulses for one cycle, starting in the cycle after the byte was accepted, with cmd_two = 0, cmd_byte0 = the byte and cmd_byte1 = 0.
- R3: With duplicate mode off, a first byte with high nibble 0x8-0xF is held. The next accepted byte completes the command, which is then released with cmd_two = 1, cmd_byte0 = first byte and cmd_byte1 = second byte. Nothing is released after the first byte alone.
- R4: A released command whose first byte has high nibble 0x8 sets duplicate mode to bit 0 of its second byte. The new mode applies from the next command on.
- R5: With duplicate mode on, nothing is released after the first copy. The command is released when the last byte of an identical second copy is accepted.
- R6: With duplicate mode on, if any byte of the second copy differs from the matching byte of the first copy, the command is dropped at once and err goes high. Because the first bytes are compared, copies of different lengths also fail. err stays high through later commands that are released.
- R7: After a mismatch, the next accepted byte is treated as the first byte of a new first copy.
- R8: err goes low only when a command whose first byte has high nibble 0x7 is released. In duplicate mode, a single copy of that command leaves err high.
- R9: Each accepted byte raises busy for exactly BUSY_CYC cycles (default 3). A byte offered while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | BYTE_W | Received command byte |
| busy | output | 1 | High while the last accepted byte is being processed |
| cmd_valid | output | 1 | One-cycle pulse: a validated command is released |
| cmd_two | output | 1 | Released command has two bytes |
| cmd_byte0 | output | BYTE_W | First byte of the released command |
| cmd_byte1 | output | BYTE_W | Second byte of the released command (0 for one-byte commands) |
| err | output | 1 | Sticky duplicate-mismatch error |

## Verification
The assertions assume that the receiver presents a byte only as a single-cycle rx_valid pulse. They also assume that a pulse arriving while busy is high is simply lost. Because of this, every release and every busy rise can be traced back to one accepted byte in the previous cycle. The bench waits for busy to fall before each legal byte. It offers exactly one deliberately early byte to show the drop. It drives every pulse one cycle wide, between falling edges.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_SETUP  = 4'h8;
  localparam logic [OP_W-1:0] OP_ERRCLR = 4'h7;
  localparam int MODE_BIT = 0;

  typedef enum logic [1:0] {
    S_A0 = 2'd0,
    S_A1 = 2'd1,
    S_B0 = 2'd2,
    S_B1 = 2'd3
  } pair_state_t;

  function automatic logic op_is_two(input logic [OP_W-1:0] op);
    return op[OP_W-1];
  endfunction
endpackage

// File: rtl/dcg_pacer.sv
module dcg_pacer #(
  parameter int BUSY_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start)              cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dcg_pair_fsm.sv
module dcg_pair_fsm
  import dcg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              dup_on,
  output logic              rel_stb,
  output logic              rel_two,
  output logic [BYTE_W-1:0] rel_b0,
  output logic [BYTE_W-1:0] rel_b1,
  output logic              mismatch
);
  localparam int OP_LSB = BYTE_W - OP_W;

  pair_state_t       st_q, st_d;
  logic [BYTE_W-1:0] a0_q, a0_d, a1_q, a1_d;
  logic              in_two, a0_two;

  assign in_two = op_is_two(byte_in[BYTE_W-1:OP_LSB]);
  assign a0_two = op_is_two(a0_q[BYTE_W-1:OP_LSB]);

  always_comb begin
    st_d     = st_q;
    a0_d     = a0_q;
    a1_d     = a1_q;
    rel_stb  = 1'b0;
    rel_two  = 1'b0;
    rel_b0   = a0_q;
    rel_b1   = '0;
    mismatch = 1'b0;
    if (byte_stb) begin
      unique case (st_q)
        S_A0: begin
          if (in_two) begin
            a0_d = byte_in;
            st_d = S_A1;
          end else if (dup_on) begin
            a0_d = byte_in;
            st_d = S_B0;
          end else begin
            rel_stb = 1'b1;
            rel_b0  = byte_in;
          end
        end
        S_A1: begin
          if (dup_on) begin
            a1_d = byte_in;
            st_d = S_B0;
          end else begin
            rel_stb = 1'b1;
            rel_two = 1'b1;
            rel_b1  = byte_in;
            st_d    = S_A0;
          end
        end
        S_B0: begin
          if (byte_in != a0_q) begin
            mismatch = 1'b1;
            st_d     = S_A0;
          end else if (a0_two) begin
            st_d = S_B1;
          end else begin
            rel_stb = 1'b1;
            st_d    = S_A0;
          end
        end
        S_B1: begin
          if (byte_in != a1_q) begin
            mismatch = 1'b1;
          end else begin
            rel_stb = 1'b1;
            rel_two = 1'b1;
            rel_b1  = a1_q;
          end
          st_d = S_A0;
        end
        default: st_d = S_A0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_A0;
      a0_q <= '0;
      a1_q <= '0;
    end else if (byte_stb) begin
      st_q <= st_d;
      a0_q <= a0_d;
      a1_q <= a1_d;
    end
  end
endmodule

// File: rtl/dcg_ctl.sv
module dcg_ctl
  import dcg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rel_stb,
  input  logic [BYTE_W-1:0] rel_b0,
  input  logic [BYTE_W-1:0] rel_b1,
  input  logic              mismatch,
  output logic              dup_on,
  output logic              err
);
  localparam int OP_LSB = BYTE_W - OP_W;

  logic dup_d, err_d, is_setup, is_clr, upd_en;

  assign is_setup = rel_stb && (rel_b0[BYTE_W-1:OP_LSB] == OP_SETUP);
  assign is_clr   = rel_stb && (rel_b0[BYTE_W-1:OP_LSB] == OP_ERRCLR);
  assign upd_en   = is_setup || is_clr || mismatch;

  always_comb begin
    dup_d = dup_on;
    err_d = err;
    if (is_setup) dup_d = rel_b1[MODE_BIT];
    if (mismatch) err_d = 1'b1;
    else if (is_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dup_on <= 1'b0;
      err    <= 1'b0;
    end else if (upd_en) begin
      dup_on <= dup_d;
      err    <= err_d;
    end
  end
endmodule

// File: rtl/dup_cmd_gate.sv
module dup_cmd_gate #(
  parameter int BYTE_W   = 8,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              busy,
  output logic              cmd_valid,
  output logic              cmd_two,
  output logic [BYTE_W-1:0] cmd_byte0,
  output logic [BYTE_W-1:0] cmd_byte1,
  output logic              err
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              byte_stb, dup_on;
  logic              rel_stb, rel_two, mismatch;
  logic [BYTE_W-1:0] rel_b0, rel_b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign byte_stb = rx_valid && !busy;

  dcg_pacer #(.BUSY_CYC(BUSY_CYC)) pacer_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (byte_stb),
    .busy  (busy)
  );

  dcg_pair_fsm #(.BYTE_W(BYTE_W)) pair_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .byte_stb (byte_stb),
    .byte_in  (rx_byte),
    .dup_on   (dup_on),
    .rel_stb  (rel_stb),
    .rel_two  (rel_two),
    .rel_b0   (rel_b0),
    .rel_b1   (rel_b1),
    .mismatch (mismatch)
  );

  dcg_ctl #(.BYTE_W(BYTE_W)) ctl_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rel_stb  (rel_stb),
    .rel_b0   (rel_b0),
    .rel_b1   (rel_b1),
    .mismatch (mismatch),
    .dup_on   (dup_on),
    .err      (err)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cmd_valid <= 1'b0;
    else            cmd_valid <= rel_stb;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_two   <= 1'b0;
      cmd_byte0 <= '0;
      cmd_byte1 <= '0;
    end else if (rel_stb) begin
      cmd_two   <= rel_two;
      cmd_byte0 <= rel_b0;
      cmd_byte1 <= rel_b1;
    end
  end
endmodule

// File: rtl/dup_cmd_gate_chk.sv
module dup_cmd_gate_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              busy,
  input logic              cmd_valid,
  input logic              cmd_two,
  input logic [BYTE_W-1:0] cmd_byte0,
  input logic              err
);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !busy) |=> busy);

  // R2
  release_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(rx_valid && !busy));

  // R3
  length_matches_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_two == cmd_byte0[BYTE_W-1]));

  // R6
  err_rise_no_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !cmd_valid);

  // R8
  err_fall_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> (cmd_valid && cmd_byte0[BYTE_W-1:BYTE_W-4] == 4'h7));
endmodule

bind dup_cmd_gate dup_cmd_gate_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .rx_valid  (rx_valid),
  .busy      (busy),
  .cmd_valid (cmd_valid),
  .cmd_two   (cmd_two),
  .cmd_byte0 (cmd_byte0),
  .err       (err)
);

// File: tb/dup_cmd_gate_tb_top.sv
`timescale 1ns/1ps
module dup_cmd_gate_tb_top;
  localparam int BUSY_CYC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       busy, cmd_valid, cmd_two, err;
  logic [7:0] cmd_byte0, cmd_byte1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic       g_v, g_two, g_err, g_busy;
  logic [7:0] g_b0, g_b1;

  always #5 clk = ~clk;

  dup_cmd_gate #(.BYTE_W(8), .BUSY_CYC(BUSY_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_two(cmd_two),
    .cmd_byte0(cmd_byte0), .cmd_byte1(cmd_byte1), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<20000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    g_v = cmd_valid; g_two = cmd_two; g_b0 = cmd_byte0; g_b1 = cmd_byte1;
    g_err = err; g_busy = busy;
  endtask

  task automatic t_reset();
    check(busy == 0 && err == 0 && cmd_valid == 0, "R1 reset outputs",
          {busy, err, cmd_valid}, 0);
  endtask

  task automatic t_single_one();
    send(8'h35);
    check(g_v && !g_two && g_b0 == 8'h35 && g_b1 == 0, "R2 one-byte release",
          {g_v, g_two, g_b0, g_b1}, {1'b1, 1'b0, 8'h35, 8'h00});
    @(negedge clk);
    check(cmd_valid == 0, "R2 single pulse", cmd_valid, 0);
  endtask

  task automatic t_single_two();
    send(8'hC4);
    check(!g_v, "R3 held after first byte", g_v, 0);
    send(8'h9A);
    check(g_v && g_two && g_b0 == 8'hC4 && g_b1 == 8'h9A, "R3 two-byte release",
          {g_v, g_two, g_b0, g_b1}, {1'b1, 1'b1, 8'hC4, 8'h9A});
  endtask

  task automatic t_busy();
    int n;
    send(8'hA1);
    check(g_busy, "R9 busy after byte", g_busy, 1);
    rx_valid = 1'b1; rx_byte = 8'h11;
    @(negedge clk);
    rx_valid = 1'b0;
    check(!cmd_valid, "R9 byte during busy ignored", cmd_valid, 0);
    n = 1;
    while (busy) begin @(negedge clk); n++; end
    check(n == BUSY_CYC, "R9 busy length", n, BUSY_CYC);
    send(8'h2B);
    check(g_v && g_b0 == 8'hA1 && g_b1 == 8'h2B, "R9 dropped byte left no trace",
          {g_v, g_b0, g_b1}, {1'b1, 8'hA1, 8'h2B});
  endtask

  task automatic t_enter_dup();
    send(8'h80); send(8'h01);
    check(g_v && g_b0 == 8'h80 && g_b1 == 8'h01, "R4 setup released",
          {g_v, g_b0, g_b1}, {1'b1, 8'h80, 8'h01});
    send(8'h22);
    check(!g_v, "R5 first copy not released", g_v, 0);
    send(8'h22);
    check(g_v && !g_two && g_b0 == 8'h22, "R4 R5 second copy releases",
          {g_v, g_two, g_b0}, {1'b1, 1'b0, 8'h22});
  endtask

  task automatic t_dup_two();
    send(8'hD1); send(8'h05); send(8'hD1);
    check(!g_v, "R5 no release mid second copy", g_v, 0);
    send(8'h05);
    check(g_v && g_two && g_b0 == 8'hD1 && g_b1 == 8'h05, "R5 two-byte duplicate",
          {g_v, g_two, g_b0, g_b1}, {1'b1, 1'b1, 8'hD1, 8'h05});
  endtask

  task automatic t_mismatch_tail();
    send(8'hD1); send(8'h05); send(8'hD1); send(8'h06);
    check(!g_v && g_err, "R6 second-byte mismatch", {g_v, g_err}, 2'b01);
    send(8'h44);
    check(!g_v, "R7 new first copy held", g_v, 0);
    send(8'h44);
    check(g_v && g_b0 == 8'h44 && g_err, "R7 R6 restart and sticky err",
          {g_v, g_b0, g_err}, {1'b1, 8'h44, 1'b1});
  endtask

  task automatic t_clear();
    send(8'h70);
    check(!g_v && g_err, "R8 single copy keeps err", {g_v, g_err}, 2'b01);
    send(8'h70);
    check(g_v && !g_err, "R8 duplicated clear", {g_v, g_err}, 2'b10);
  endtask

  task automatic t_mismatch_len();
    send(8'h12); send(8'h92);
    check(!g_v && g_err, "R6 length mismatch", {g_v, g_err}, 2'b01);
    send(8'h33); send(8'h33);
    check(g_v && g_b0 == 8'h33, "R7 restart after length mismatch",
          {g_v, g_b0}, {1'b1, 8'h33});
    t_clear();
  endtask

  task automatic t_mismatch_head();
    send(8'h91); send(8'h00); send(8'h92);
    check(!g_v && g_err, "R6 first-byte mismatch of two-byte", {g_v, g_err}, 2'b01);
    send(8'h00); send(8'h00);
    check(g_v && !g_two && g_b0 == 8'h00, "R7 restart after head mismatch",
          {g_v, g_two, g_b0}, {1'b1, 1'b0, 8'h00});
    t_clear();
  endtask

  task automatic t_exit_dup();
    send(8'h80); send(8'h00); send(8'h80); send(8'h00);
    check(g_v && g_b1 == 8'h00, "R4 setup clears mode", {g_v, g_b1}, {1'b1, 8'h00});
    send(8'h55);
    check(g_v && g_b0 == 8'h55, "R4 R2 single mode again", {g_v, g_b0}, {1'b1, 8'h55});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_one();
    t_single_two();
    t_busy();
    t_enter_dup();
    t_dup_two();
    t_mismatch_tail();
    t_clear();
    t_mismatch_len();
    t_mismatch_head();
    t_exit_dup();
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule